// File: doc/BRIEF.md
# AC97 Codec Command and Status Controller

This block sits between a processor register bus and the serial link to an AC97 audio codec. It handles only the command and status traffic, not the audio. Software loads a 16-bit value, then writes a register index together with a read or write flag. The block places that command in the address and data slots of the next outgoing frame. Status slots that the codec returns are captured into the same registers, and sticky flags report each step.

The link runs as a 256-bit frame. A 16-bit tag slot comes first and is followed by 20-bit slots. The frame sync output is high during the tag slot, and every bit is sent most significant first. A control register drives the codec reset line, forces sync high for a warm reset, starts the link, and reports whether the codec has declared itself ready. Each audio direction also has a width-select field for 16-bit or 20-bit samples, which the sample datapath will use.

Top module: `ac97_cmd_ctrl`

## Requirements
- R1: The registers sit at these byte offsets: control 0x00, command address 0x04, command data 0x08, transmit status 0x0C, receive status 0x10 and width select 0x14. A read returns its data one cycle after the request. Any other offset reads as zero, and writes to it have no effect.
- R2: A command-address write carries the index in bits 18:12 and the read flag in bit 19. The command is sent in the next frame: tag bit 14 is set, and slot 1 carries the flag in bit 19 and the index in bits 18:12. Transmit status bit 31 is set once slot 1 has gone out.
- R3: For a write command, tag bit 13 is set and slot 2 carries, in bits 19:4, the value that was in command-data bits 19:4 when the address was written. Transmit status bit 30 is set after slot 2 has gone out. A read command sets neither tag bit 13 nor bit 30.
- R4: The transmit flags (bits 31 and 30) and the receive flags (bits 22 and 21) are sticky. Writing 0 to a flag bit clears it. Writing 1 leaves it as it was and never sets it.
- R5: When a frame's incoming tag has bit 14 set, slot 1 bits 18:12 are captured into command-address bits 18:12 and receive bit 22 is set. When the tag has bit 13 set, slot 2 bits 19:4 are captured into command-data read bits 19:4 and receive bit 21 is set.
- R6: When the codec marks no status slot valid, both receive flags stay low.
- R7: A second command written while one is still waiting for its frame is queued. It is sent in the following frame with its own data value.
- R8: While control bit 11 is set, the codec reset output is low, the link sends no frames and control bit 15 reads 0.
- R9: While control bit 10 is set, the sync output is held high.
- R10: Control bit 15 follows bit 15 of the most recent incoming tag slot.
- R11: Width-select bits 1:0 control transmit and bits 3:2 control receive, where 01 selects 16 bits and 10 selects 20 bits. A write of 11 to a field leaves that field unchanged.
- R12: While the link runs (control bit 5 set and both reset bits clear), sync is high for exactly the 16 tag bit times of each frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the link bit rate |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, valid the cycle after bus_rd |
| codec_rst_n | output | 1 | Active-low codec reset |
| link_sync | output | 1 | Frame sync to the codec |
| link_sdo | output | 1 | Serial data to the codec |
| link_sdi | input | 1 | Serial data from the codec |

## Verification
The assertions check, on every cycle, that cold reset holds the codec reset low, that warm reset holds sync high, and that sync never stays high longer than the tag slot. They also check that the transmit flags stay set until a zero is written, that the receive address flag only rises after a captured valid slot, that neither width field ever holds 11, and that the queue slot is never filled ahead of the pending slot. Only the bench scenarios, which use a behavioural codec with its own register memory, can show that the slot encodings round-trip correctly. They also show that queued commands keep their own data, that a silent codec leaves the receive flags low, and that the ready bit tracks the codec's tag.

// File: rtl/ac97_cmd_pkg.sv
package ac97_cmd_pkg;
  localparam int IDX_W = 7;
  localparam int DAT_W = 16;

  localparam int OFF_CTRL = 'h00;
  localparam int OFF_ADDR = 'h04;
  localparam int OFF_DATA = 'h08;
  localparam int OFF_TXS  = 'h0C;
  localparam int OFF_RXS  = 'h10;
  localparam int OFF_WSEL = 'h14;

  localparam int CTRL_READY = 15;
  localparam int CTRL_COLD  = 11;
  localparam int CTRL_WARM  = 10;
  localparam int CTRL_START = 5;

  localparam int CMD_RD_BIT  = 19;
  localparam int CMD_IDX_LSB = 12;
  localparam int CMD_DAT_LSB = 4;

  localparam int TX_ADDR_BIT = 31;
  localparam int TX_DATA_BIT = 30;
  localparam int RX_ADDR_BIT = 22;
  localparam int RX_DATA_BIT = 21;

  typedef struct packed {
    logic             rd;
    logic [IDX_W-1:0] idx;
    logic [DAT_W-1:0] data;
  } cmd_t;
endpackage

// File: rtl/ac97_cmd_regs.sv
module ac97_cmd_regs
  import ac97_cmd_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              cold_o,
  output logic              warm_o,
  output logic              start_o,
  output logic              cmd_go_o,
  output cmd_t              cmd_o,
  output logic [3:0]        flags_o,
  output logic [3:0]        wsel_o,
  input  logic              tx_a_done,
  input  logic              tx_d_done,
  input  logic              rdy_stb,
  input  logic              rdy_val,
  input  logic              rx_a_stb,
  input  logic [IDX_W-1:0]  rx_a_idx,
  input  logic              rx_d_stb,
  input  logic [DAT_W-1:0]  rx_d_val
);
  logic [DAT_W-1:0] wdat_q, rx_dat_q;
  logic [IDX_W-1:0] rx_idx_q;
  logic             tx_a_q, tx_d_q, rx_a_q, rx_d_q, ready_q;
  logic [1:0]       wtx_q, wrx_q;

  logic sel_ctrl, sel_addr, sel_data, sel_txs, sel_rxs, sel_wsel;
  assign sel_ctrl = bus_wr && (bus_addr == ADDR_W'(OFF_CTRL));
  assign sel_addr = bus_wr && (bus_addr == ADDR_W'(OFF_ADDR));
  assign sel_data = bus_wr && (bus_addr == ADDR_W'(OFF_DATA));
  assign sel_txs  = bus_wr && (bus_addr == ADDR_W'(OFF_TXS));
  assign sel_rxs  = bus_wr && (bus_addr == ADDR_W'(OFF_RXS));
  assign sel_wsel = bus_wr && (bus_addr == ADDR_W'(OFF_WSEL));

  logic unused_wdata;
  assign unused_wdata = ^bus_wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      cold_o   <= 1'b0;
      warm_o   <= 1'b0;
      start_o  <= 1'b0;
      cmd_go_o <= 1'b0;
      cmd_o    <= '0;
      wdat_q   <= '0;
      rx_dat_q <= '0;
      rx_idx_q <= '0;
      tx_a_q   <= 1'b0;
      tx_d_q   <= 1'b0;
      rx_a_q   <= 1'b0;
      rx_d_q   <= 1'b0;
      ready_q  <= 1'b0;
      wtx_q    <= '0;
      wrx_q    <= '0;
      bus_rdata <= '0;
    end else begin
      if (sel_ctrl) begin
        cold_o  <= bus_wdata[CTRL_COLD];
        warm_o  <= bus_wdata[CTRL_WARM];
        start_o <= bus_wdata[CTRL_START];
      end
      if (sel_data) wdat_q <= bus_wdata[CMD_DAT_LSB +: DAT_W];
      cmd_go_o <= sel_addr;
      if (sel_addr) begin
        cmd_o.rd   <= bus_wdata[CMD_RD_BIT];
        cmd_o.idx  <= bus_wdata[CMD_IDX_LSB +: IDX_W];
        cmd_o.data <= wdat_q;
      end
      // set wins over clear; writing 1 keeps, writing 0 clears
      tx_a_q <= tx_a_done | (tx_a_q & ~(sel_txs & ~bus_wdata[TX_ADDR_BIT]));
      tx_d_q <= tx_d_done | (tx_d_q & ~(sel_txs & ~bus_wdata[TX_DATA_BIT]));
      rx_a_q <= rx_a_stb  | (rx_a_q & ~(sel_rxs & ~bus_wdata[RX_ADDR_BIT]));
      rx_d_q <= rx_d_stb  | (rx_d_q & ~(sel_rxs & ~bus_wdata[RX_DATA_BIT]));
      if (rx_a_stb) rx_idx_q <= rx_a_idx;
      if (rx_d_stb) rx_dat_q <= rx_d_val;
      if (cold_o) ready_q <= 1'b0;
      else if (rdy_stb) ready_q <= rdy_val;
      if (sel_wsel) begin
        if (bus_wdata[1:0] != 2'b11) wtx_q <= bus_wdata[1:0];
        if (bus_wdata[3:2] != 2'b11) wrx_q <= bus_wdata[3:2];
      end
      bus_rdata <= '0;
      if (bus_rd) begin
        case (bus_addr)
          ADDR_W'(OFF_CTRL): begin
            bus_rdata[CTRL_READY] <= ready_q;
            bus_rdata[CTRL_COLD]  <= cold_o;
            bus_rdata[CTRL_WARM]  <= warm_o;
            bus_rdata[CTRL_START] <= start_o;
          end
          ADDR_W'(OFF_ADDR): bus_rdata[CMD_IDX_LSB +: IDX_W] <= rx_idx_q;
          ADDR_W'(OFF_DATA): bus_rdata[CMD_DAT_LSB +: DAT_W] <= rx_dat_q;
          ADDR_W'(OFF_TXS): begin
            bus_rdata[TX_ADDR_BIT] <= tx_a_q;
            bus_rdata[TX_DATA_BIT] <= tx_d_q;
          end
          ADDR_W'(OFF_RXS): begin
            bus_rdata[RX_ADDR_BIT] <= rx_a_q;
            bus_rdata[RX_DATA_BIT] <= rx_d_q;
          end
          ADDR_W'(OFF_WSEL): bus_rdata[3:0] <= {wrx_q, wtx_q};
          default: bus_rdata <= '0;
        endcase
      end
    end
  end

  assign flags_o = {tx_a_q, tx_d_q, rx_a_q, rx_d_q};
  assign wsel_o  = {wrx_q, wtx_q};
endmodule

// File: rtl/ac97_frame_tx.sv
module ac97_frame_tx
  import ac97_cmd_pkg::*;
#(
  parameter int FRAME_BITS = 256,
  parameter int TAG_BITS   = 16,
  parameter int SLOT_BITS  = 20,
  localparam int CNT_W     = $clog2(FRAME_BITS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             warm,
  input  logic             cmd_go,
  input  cmd_t             cmd,
  output logic             sync_o,
  output logic             sdo_o,
  output logic [CNT_W-1:0] pos_o,
  output logic             vld_o,
  output logic             a_done,
  output logic             d_done,
  output logic             pend_v,
  output logic             queue_v
);
  localparam int WORD_W = TAG_BITS + 2*SLOT_BITS;
  localparam int S1_END = TAG_BITS + SLOT_BITS - 1;
  localparam int S2_END = TAG_BITS + 2*SLOT_BITS - 1;

  logic [CNT_W-1:0]  cnt;
  logic [WORD_W-1:0] sh;
  cmd_t act, pend, que, act_n, pend_n, que_n;
  logic act_v, act_v_n, pend_v_n, que_v_n;
  logic frame_start;

  assign frame_start = run && (cnt == '0);

  always_comb begin
    act_n = act;  act_v_n = act_v;
    pend_n = pend; pend_v_n = pend_v;
    que_n = que;  que_v_n = queue_v;
    if (frame_start) begin
      act_n = pend;  act_v_n = pend_v;
      pend_n = que;  pend_v_n = queue_v;
      que_v_n = 1'b0;
    end
    if (cmd_go) begin
      if (!pend_v_n) begin
        pend_n = cmd; pend_v_n = 1'b1;
      end else begin
        que_n = cmd;  que_v_n = 1'b1;
      end
    end
  end

  logic [TAG_BITS-1:0]  tag_w;
  logic [SLOT_BITS-1:0] s1_w, s2_w;
  logic [WORD_W-1:0]    word;

  always_comb begin
    tag_w = '0;
    tag_w[TAG_BITS-1] = 1'b1;
    tag_w[TAG_BITS-2] = act_v_n;
    tag_w[TAG_BITS-3] = act_v_n & ~act_n.rd;
    s1_w = '0;
    if (act_v_n) begin
      s1_w[SLOT_BITS-1] = act_n.rd;
      s1_w[SLOT_BITS-2 -: IDX_W] = act_n.idx;
    end
    s2_w = '0;
    if (act_v_n && !act_n.rd) s2_w[SLOT_BITS-1 -: DAT_W] = act_n.data;
    word = {tag_w, s1_w, s2_w};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0; sh <= '0;
      act <= '0; pend <= '0; que <= '0;
      act_v <= 1'b0; pend_v <= 1'b0; queue_v <= 1'b0;
      sync_o <= 1'b0; sdo_o <= 1'b0; pos_o <= '0; vld_o <= 1'b0;
      a_done <= 1'b0; d_done <= 1'b0;
    end else begin
      act <= act_n; act_v <= act_v_n;
      pend <= pend_n; pend_v <= pend_v_n;
      que <= que_n; queue_v <= que_v_n;
      vld_o <= run;
      pos_o <= cnt;
      a_done <= run && act_v && (cnt == CNT_W'(S1_END));
      d_done <= run && act_v && !act.rd && (cnt == CNT_W'(S2_END));
      if (run) begin
        cnt    <= (cnt == CNT_W'(FRAME_BITS-1)) ? '0 : cnt + 1'b1;
        sync_o <= (cnt < CNT_W'(TAG_BITS));
        if (frame_start) begin
          sdo_o <= word[WORD_W-1];
          sh    <= {word[WORD_W-2:0], 1'b0};
        end else begin
          sdo_o <= sh[WORD_W-1];
          sh    <= {sh[WORD_W-2:0], 1'b0};
        end
      end else begin
        cnt    <= '0;
        sync_o <= warm;
        sdo_o  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ac97_frame_rx.sv
module ac97_frame_rx
  import ac97_cmd_pkg::*;
#(
  parameter int TAG_BITS  = 16,
  parameter int SLOT_BITS = 20,
  parameter int CNT_W     = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             vld,
  input  logic [CNT_W-1:0] pos,
  input  logic             sdi,
  output logic             rdy_stb,
  output logic             rdy_val,
  output logic             a_stb,
  output logic [IDX_W-1:0] a_idx,
  output logic             d_stb,
  output logic [DAT_W-1:0] d_val
);
  localparam int S1_END = TAG_BITS + SLOT_BITS - 1;
  localparam int S2_END = TAG_BITS + 2*SLOT_BITS - 1;

  logic [SLOT_BITS-1:0] sh, word;
  logic tag_a, tag_d;

  assign word = {sh[SLOT_BITS-2:0], sdi};

  logic unused_bits;
  assign unused_bits = ^{sh[SLOT_BITS-1], word};

  always_ff @(posedge clk) begin
    if (rst) begin
      sh <= '0; tag_a <= 1'b0; tag_d <= 1'b0;
      rdy_stb <= 1'b0; rdy_val <= 1'b0;
      a_stb <= 1'b0; a_idx <= '0; d_stb <= 1'b0; d_val <= '0;
    end else begin
      rdy_stb <= 1'b0;
      a_stb   <= 1'b0;
      d_stb   <= 1'b0;
      if (vld) begin
        sh <= word;
        if (pos == CNT_W'(TAG_BITS-1)) begin
          rdy_stb <= 1'b1;
          rdy_val <= word[TAG_BITS-1];
          tag_a   <= word[TAG_BITS-2];
          tag_d   <= word[TAG_BITS-3];
        end
        if (pos == CNT_W'(S1_END)) begin
          a_stb <= tag_a;
          a_idx <= word[SLOT_BITS-2 -: IDX_W];
        end
        if (pos == CNT_W'(S2_END)) begin
          d_stb <= tag_d;
          d_val <= word[SLOT_BITS-1 -: DAT_W];
        end
      end
    end
  end
endmodule

// File: rtl/ac97_cmd_ctrl.sv
module ac97_cmd_ctrl
  import ac97_cmd_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int FRAME_BITS = 256,
  parameter int TAG_BITS   = 16,
  parameter int SLOT_BITS  = 20,
  localparam int CNT_W     = $clog2(FRAME_BITS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              codec_rst_n,
  output logic              link_sync,
  output logic              link_sdo,
  input  logic              link_sdi
);
  logic cold, warm, start, run, cmd_go;
  cmd_t cmd;
  logic [3:0] flags, wsel;
  logic tx_a_done, tx_d_done, rdy_stb, rdy_val, rx_a_stb, rx_d_stb;
  logic [IDX_W-1:0] rx_a_idx;
  logic [DAT_W-1:0] rx_d_val;
  logic [CNT_W-1:0] pos;
  logic vld, pend_v, queue_v;

  assign run = start & ~cold & ~warm;

  ac97_cmd_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk, .rst, .bus_addr, .bus_wr, .bus_rd, .bus_wdata, .bus_rdata,
    .cold_o(cold), .warm_o(warm), .start_o(start),
    .cmd_go_o(cmd_go), .cmd_o(cmd), .flags_o(flags), .wsel_o(wsel),
    .tx_a_done, .tx_d_done, .rdy_stb, .rdy_val,
    .rx_a_stb, .rx_a_idx, .rx_d_stb, .rx_d_val
  );

  ac97_frame_tx #(.FRAME_BITS(FRAME_BITS), .TAG_BITS(TAG_BITS), .SLOT_BITS(SLOT_BITS)) u_tx (
    .clk, .rst, .run, .warm, .cmd_go, .cmd,
    .sync_o(link_sync), .sdo_o(link_sdo), .pos_o(pos), .vld_o(vld),
    .a_done(tx_a_done), .d_done(tx_d_done), .pend_v, .queue_v
  );

  ac97_frame_rx #(.TAG_BITS(TAG_BITS), .SLOT_BITS(SLOT_BITS), .CNT_W(CNT_W)) u_rx (
    .clk, .rst, .vld, .pos, .sdi(link_sdi),
    .rdy_stb, .rdy_val, .a_stb(rx_a_stb), .a_idx(rx_a_idx),
    .d_stb(rx_d_stb), .d_val(rx_d_val)
  );

  always_ff @(posedge clk) begin
    if (rst) codec_rst_n <= 1'b1;
    else     codec_rst_n <= ~cold;
  end

  // observed by the bound checker; the width select feeds the sample path
  logic unused_obs;
  assign unused_obs = ^{flags, wsel, pend_v, queue_v};
endmodule

// File: rtl/ac97_cmd_chk.sv
module ac97_cmd_chk #(
  parameter int TAG_BITS = 16
) (
  input logic       clk,
  input logic       rst,
  input logic       cold,
  input logic       warm,
  input logic       vld,
  input logic       codec_rst_n,
  input logic       link_sync,
  input logic       bus_wr,
  input logic [7:0] bus_addr,
  input logic [31:0] bus_wdata,
  input logic [3:0] flags,
  input logic       rx_a_stb,
  input logic [3:0] wsel,
  input logic       pend_v,
  input logic       queue_v
);
  logic [7:0] sync_run;
  always_ff @(posedge clk) begin
    if (rst) sync_run <= '0;
    else if (vld && link_sync) sync_run <= sync_run + 1'b1;
    else sync_run <= '0;
  end

  p_cold_hold_r8: assert property (@(posedge clk) disable iff (rst)
    cold |=> !codec_rst_n);
  p_warm_sync_r9: assert property (@(posedge clk) disable iff (rst)
    warm |=> link_sync);
  p_tx_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    (flags[3] && !(bus_wr && bus_addr == 8'h0C && !bus_wdata[31])) |=> flags[3]);
  p_rx_source_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(flags[1]) |-> $past(rx_a_stb));
  p_width_legal_r11: assert property (@(posedge clk) disable iff (rst)
    (wsel[1:0] != 2'b11) && (wsel[3:2] != 2'b11));
  p_queue_order_r7: assert property (@(posedge clk) disable iff (rst)
    queue_v |-> pend_v);
  p_sync_len_r12: assert property (@(posedge clk) disable iff (rst)
    (vld && link_sync) |-> (sync_run < 8'(TAG_BITS)));
endmodule

bind ac97_cmd_ctrl ac97_cmd_chk #(.TAG_BITS(TAG_BITS)) u_chk (
  .clk(clk), .rst(rst), .cold(cold), .warm(warm), .vld(vld),
  .codec_rst_n(codec_rst_n), .link_sync(link_sync),
  .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .flags(flags), .rx_a_stb(rx_a_stb), .wsel(wsel),
  .pend_v(pend_v), .queue_v(queue_v)
);

// File: tb/tb_ac97_cmd_ctrl.sv
`timescale 1ns/1ps
module tb_ac97_cmd_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        codec_rst_n, link_sync, link_sdo;
  logic        link_sdi = 1'b0;

  always #2 clk = ~clk;

  ac97_cmd_ctrl dut (
    .clk, .rst, .bus_addr, .bus_wr, .bus_rd, .bus_wdata, .bus_rdata,
    .codec_rst_n, .link_sync, .link_sdo, .link_sdi
  );

  int total = 0, fails = 0;
  bit done = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  // behavioural codec
  logic [15:0] cmem [128];
  bit codec_rdy = 1'b1, mute = 1'b0;
  int pos = 1000;
  bit prev_sync = 1'b0;
  logic [55:0] in_word = '0, out_word = '0;
  bit rep_v = 0;
  logic [6:0]  rep_idx = '0;
  logic [15:0] rep_dat = '0;

  initial for (int i = 0; i < 128; i++) cmem[i] = '0;

  always @(negedge clk) begin
    if (link_sync && !prev_sync) pos = 0; else pos = pos + 1;
    prev_sync = link_sync;
    if (pos == 0) begin
      out_word = {codec_rdy, rep_v & !mute, rep_v & !mute, 13'b0,
                  1'b0, rep_idx, 12'b0, rep_dat, 4'b0};
      rep_v = 0;
    end
    if (pos < 56) in_word = {in_word[54:0], link_sdo};
    if (pos == 55 && in_word[54]) begin
      if (in_word[39]) begin
        rep_v = 1; rep_idx = in_word[38:32]; rep_dat = cmem[in_word[38:32]];
      end else if (in_word[53]) begin
        cmem[in_word[38:32]] = in_word[19:4];
      end
    end
    link_sdi = (pos < 56) ? out_word[55-pos] : 1'b0;
  end

  typedef struct packed {
    logic rd; logic [6:0] idx; logic [15:0] wd;
    logic [1:0] etx; logic [1:0] erx; logic [15:0] ev;
  } vec_t;
  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 7'h02, 16'h8000, 2'b11, 2'b00, 16'h0000},
    '{1'b0, 7'h7F, 16'hFFFF, 2'b11, 2'b00, 16'h0000},
    '{1'b1, 7'h02, 16'h0000, 2'b10, 2'b11, 16'h8000},
    '{1'b1, 7'h7F, 16'h0000, 2'b10, 2'b11, 16'hFFFF},
    '{1'b0, 7'h10, 16'h1234, 2'b11, 2'b00, 16'h0000},
    '{1'b1, 7'h10, 16'h0000, 2'b10, 2'b11, 16'h1234},
    '{1'b1, 7'h05, 16'h0000, 2'b10, 2'b11, 16'h0000}
  };

  initial begin
    logic [31:0] r;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    // reset state
    bus_read(8'h00, r); chk("R1 ctrl reset", r, 32'h0);
    bus_read(8'h0C, r); chk("R4 tx reset", r, 32'h0);
    bus_read(8'h10, r); chk("R5 rx reset", r, 32'h0);
    chk("R8 reset pin idle", {31'b0, codec_rst_n}, 32'h1);
    chk("R12 sync idle", {31'b0, link_sync}, 32'h0);

    // cold reset then start
    bus_write(8'h00, 32'h0820);
    repeat (3) @(negedge clk);
    chk("R8 codec reset low", {31'b0, codec_rst_n}, 32'h0);
    bus_write(8'h00, 32'h0020);
    repeat (600) @(negedge clk);
    bus_read(8'h00, r); chk("R10 ready set", r, 32'h8020);

    // table of commands
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VECS[i];
      if (!v.rd) bus_write(8'h08, {12'b0, v.wd, 4'b0});
      bus_write(8'h04, {12'b0, v.rd, v.idx, 12'b0});
      repeat (800) @(negedge clk);
      bus_read(8'h0C, r); chk(v.rd ? "R2 tx flags read" : "R3 tx flags write", r, {v.etx, 30'b0});
      bus_read(8'h10, r); chk("R5 rx flags", r, {9'b0, v.erx, 21'b0});
      if (v.rd) begin
        bus_read(8'h04, r); chk("R5 captured index", r, {13'b0, v.idx, 12'b0});
        bus_read(8'h08, r); chk("R5 captured data", r, {12'b0, v.ev, 4'b0});
      end else begin
        chk("R3 codec memory", {16'b0, cmem[v.idx]}, {16'b0, v.wd});
      end
      bus_write(8'h0C, 32'h0);
      bus_write(8'h10, 32'h0);
    end

    // sticky / write-zero-to-clear
    bus_write(8'h08, 32'h000ABCD0);
    bus_write(8'h04, 32'h00033000);
    repeat (800) @(negedge clk);
    bus_write(8'h0C, 32'h40000000);
    bus_read(8'h0C, r); chk("R4 clear bit31 keep bit30", r, 32'h40000000);
    bus_write(8'h0C, 32'h80000000);
    bus_read(8'h0C, r); chk("R4 write one never sets", r, 32'h0);
    bus_write(8'h04, 32'h000B3000);
    repeat (800) @(negedge clk);
    bus_write(8'h10, 32'h00400000);
    bus_read(8'h10, r); chk("R4 rx partial clear", r, 32'h00400000);
    bus_write(8'h10, 32'h0);
    bus_write(8'h0C, 32'h0);

    // silent codec
    mute = 1'b1;
    bus_write(8'h04, 32'h00082000);
    repeat (800) @(negedge clk);
    bus_read(8'h10, r); chk("R6 no answer rx low", r, 32'h0);
    bus_read(8'h0C, r); chk("R6 request still sent", r, 32'h80000000);
    mute = 1'b0;
    bus_write(8'h0C, 32'h0);

    // queued commands
    bus_write(8'h08, 32'h00011110);
    bus_write(8'h04, 32'h00020000);
    bus_write(8'h08, 32'h00022220);
    bus_write(8'h04, 32'h00021000);
    repeat (800) @(negedge clk);
    chk("R7 first command", {16'b0, cmem[7'h20]}, 32'h1111);
    chk("R7 queued command", {16'b0, cmem[7'h21]}, 32'h2222);
    bus_write(8'h0C, 32'h0);

    // width select
    bus_write(8'h14, 32'h6);
    bus_read(8'h14, r); chk("R11 width fields", r, 32'h6);
    bus_write(8'h14, 32'hB);
    bus_read(8'h14, r); chk("R11 illegal field ignored", r, 32'hA);

    // unmapped
    bus_write(8'h40, 32'hFFFFFFFF);
    bus_read(8'h40, r); chk("R1 unmapped reads zero", r, 32'h0);
    bus_read(8'h18, r); chk("R1 unmapped 0x18", r, 32'h0);

    // ready follows tag
    codec_rdy = 1'b0;
    repeat (600) @(negedge clk);
    bus_read(8'h00, r); chk("R10 ready dropped", r, 32'h0020);
    codec_rdy = 1'b1;
    repeat (600) @(negedge clk);
    bus_read(8'h00, r); chk("R10 ready back", r, 32'h8020);

    // warm reset
    bus_write(8'h00, 32'h0420);
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      if (k == 10 || k == 299) chk("R9 sync held high", {31'b0, link_sync}, 32'h1);
    end
    bus_write(8'h00, 32'h0020);
    repeat (600) @(negedge clk);

    // cold reset with codec ready
    bus_write(8'h00, 32'h0820);
    bus_read(8'h00, r); chk("R8 ready cleared in cold", r, 32'h0820);
    begin
      int highs = 0;
      for (int k = 0; k < 300; k++) begin
        @(negedge clk);
        if (link_sync) highs++;
      end
      chk("R8 no frames in cold", highs, 0);
    end
    chk("R8 reset pin low", {31'b0, codec_rst_n}, 32'h0);
    bus_write(8'h00, 32'h0020);
    repeat (20) @(negedge clk);
    chk("R8 reset pin released", {31'b0, codec_rst_n}, 32'h1);

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule